// File: doc/BRIEF.md
# Bus Acknowledge Timeout Monitor

This block guards the system bus against cycles that never complete. While the arbiter has a bus cycle granted and in flight, a down-counter steps once on every strobe of a 2 MHz clock-enable. If the addressed target acknowledges, the arbiter drops its grant and the counter snaps back to its reload value. If the count instead runs out, the block fires a one-cycle bus fault toward the memory controller and the arbiter. It also latches a sticky error flag, and that flag drives both a level-15 interrupt request and the diagnostic indicator.

The error flag is shared with a separate watchdog, whose expiry arrives on its own input and sets the same flag. Software tells the two sources apart by reading the live count, which the block brings out on a port. A small write port programs the reload value and clears the flag. A reload value of zero switches the monitor off.

Top module: `bus_ack_timeout`

## Requirements
- R1: After reset the count equals the reset reload value (100), the reload register holds 100, and bus_fault_o, err_o, irq15_o and diag_led_o are all 0.
- R2: While grant_i is 1 and the reload value is nonzero, each rising edge with tick_i = 1 lowers a nonzero count by exactly one. An edge with tick_i = 0 leaves the count unchanged.
- R3: On every rising edge with grant_i = 0, the count is loaded with the current reload value, whatever tick_i is.
- R4: The edge that takes the count from 1 to 0 raises bus_fault_o for exactly one cycle. With grant_i still 1, the count then stays at 0 and no further pulse follows.
- R5: err_o becomes 1 on the edge after a bus_fault_o pulse, or on the edge that samples ext_expire_i = 1. It then stays 1 until it is cleared. A watchdog expiry leaves the count unchanged.
- R6: irq15_o and diag_led_o always equal err_o.
- R7: A write with wr_en_i = 1 to address 0x00044000 clears err_o on the next edge, and the data bits are ignored. If a set source (a fault pulse or ext_expire_i) is present in the same cycle, the set wins and err_o stays 1.
- R8: A write to address 0x00044004 stores wr_data_i[15:0] as the reload value on the next edge. The count takes up the new value on the first later edge with grant_i = 0.
- R9: A reload value of 0 disables the monitor: the count is held at 0 and no bus_fault_o pulse or error is produced, however long the grant lasts.
- R10: A write to any other address changes neither the reload value nor err_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 2 MHz clock-enable strobe, one cycle wide |
| grant_i | input | 1 | Arbiter acknowledge; 1 while a granted bus cycle awaits completion |
| ext_expire_i | input | 1 | Watchdog expiry pulse that shares the error flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (32) | Register write address |
| wr_data_i | input | CNT_W (16) | Register write data |
| count_o | output | CNT_W (16) | Live counter value, readable by software |
| bus_fault_o | output | 1 | One-cycle bus timeout fault to memory controller and arbiter |
| err_o | output | 1 | Sticky timeout error flag (status bit 15) |
| irq15_o | output | 1 | Level-15 interrupt request |
| diag_led_o | output | 1 | Diagnostic indicator drive |

## Verification
The assertions assume that every input is synchronous to clk_i and is sampled only at the rising edge. They take tick_i to be a plain enable with no width rule, and they take ext_expire_i and the write strobe to be free of any ordering constraint relative to the grant. The decrement and fault properties also assume that the reload value is changed only through the write port. The bench drives every input on the falling edge, so no value changes near a sampling edge. Its stimulus covers strobes on every cycle and strobes spaced four cycles apart, grants that end early, and writes that land in the same cycle as a set source.

// File: rtl/bat_pkg.sv
package bat_pkg;

    localparam logic [31:0] BAT_CLR_ADDR  = 32'h0004_4000;
    localparam logic [31:0] BAT_LOAD_ADDR = 32'h0004_4004;

    typedef enum logic [1:0] {
        REG_NONE  = 2'd0,
        REG_CLEAR = 2'd1,
        REG_LOAD  = 2'd2
    } reg_sel_e;

endpackage

// File: rtl/bat_regif.sv
module bat_regif
    import bat_pkg::*;
#(
    parameter int              ADDR_W     = 32,
    parameter int              CNT_W      = 16,
    parameter logic [ADDR_W-1:0] CLR_ADDR  = ADDR_W'(BAT_CLR_ADDR),
    parameter logic [ADDR_W-1:0] LOAD_ADDR = ADDR_W'(BAT_LOAD_ADDR),
    parameter logic [CNT_W-1:0]  RST_RELOAD = CNT_W'(100)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic [CNT_W-1:0]  reload_o,
    output logic              clr_o
);

    typedef struct packed {
        logic [CNT_W-1:0] reload;
    } regs_t;

    regs_t    regs_d, regs_q;
    reg_sel_e sel;

    always_comb begin
        sel = REG_NONE;
        if (wr_en_i) begin
            if (wr_addr_i == CLR_ADDR)       sel = REG_CLEAR;
            else if (wr_addr_i == LOAD_ADDR) sel = REG_LOAD;
        end
        regs_d = regs_q;
        if (sel == REG_LOAD) regs_d.reload = wr_data_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '{reload: RST_RELOAD};
        else         regs_q <= regs_d;
    end

    assign reload_o = regs_q.reload;
    assign clr_o    = (sel == REG_CLEAR);

endmodule

// File: rtl/bat_counter.sv
module bat_counter #(
    parameter int               CNT_W      = 16,
    parameter logic [CNT_W-1:0] RST_RELOAD = CNT_W'(100)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_i,
    input  logic             grant_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             fault_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fault;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.fault = 1'b0;
        if (!grant_i) begin
            st_d.cnt = reload_i;
        end else if (reload_i == '0) begin
            st_d.cnt = '0;
        end else if (tick_i && (st_q.cnt != '0)) begin
            st_d.cnt   = st_q.cnt - ONE;
            st_d.fault = (st_q.cnt == ONE);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{cnt: RST_RELOAD, fault: 1'b0};
        else         st_q <= st_d;
    end

    assign count_o = st_q.cnt;
    assign fault_o = st_q.fault;

endmodule

// File: rtl/bat_errflag.sv
module bat_errflag (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic fault_i,
    input  logic ext_i,
    input  logic clr_i,
    output logic err_o
);

    typedef struct packed {
        logic err;
    } flag_t;

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (fault_i || ext_i) fl_d.err = 1'b1;
        else if (clr_i)       fl_d.err = 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) fl_q <= '{err: 1'b0};
        else         fl_q <= fl_d;
    end

    assign err_o = fl_q.err;

endmodule

// File: rtl/bus_ack_timeout.sv
module bus_ack_timeout
    import bat_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                CNT_W      = 16,
    parameter logic [ADDR_W-1:0] CLR_ADDR   = ADDR_W'(BAT_CLR_ADDR),
    parameter logic [ADDR_W-1:0] LOAD_ADDR  = ADDR_W'(BAT_LOAD_ADDR),
    parameter logic [CNT_W-1:0]  RST_RELOAD = CNT_W'(100)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              tick_i,
    input  logic              grant_i,
    input  logic              ext_expire_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              bus_fault_o,
    output logic              err_o,
    output logic              irq15_o,
    output logic              diag_led_o
);

    logic [CNT_W-1:0] reload_val;
    logic             clr_req;

    bat_regif #(
        .ADDR_W    (ADDR_W),
        .CNT_W     (CNT_W),
        .CLR_ADDR  (CLR_ADDR),
        .LOAD_ADDR (LOAD_ADDR),
        .RST_RELOAD(RST_RELOAD)
    ) u_regif (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .reload_o (reload_val),
        .clr_o    (clr_req)
    );

    bat_counter #(
        .CNT_W     (CNT_W),
        .RST_RELOAD(RST_RELOAD)
    ) u_counter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick_i),
        .grant_i (grant_i),
        .reload_i(reload_val),
        .count_o (count_o),
        .fault_o (bus_fault_o)
    );

    bat_errflag u_errflag (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .fault_i(bus_fault_o),
        .ext_i (ext_expire_i),
        .clr_i (clr_req),
        .err_o (err_o)
    );

    assign irq15_o    = err_o;
    assign diag_led_o = err_o;

endmodule

// File: rtl/bat_chk.sv
module bat_chk #(
    parameter int                ADDR_W   = 32,
    parameter int                CNT_W    = 16,
    parameter logic [ADDR_W-1:0] CLR_ADDR = '0
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              grant_i,
    input logic              ext_expire_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [CNT_W-1:0]  count_o,
    input logic              bus_fault_o,
    input logic              err_o,
    input logic [CNT_W-1:0]  reload_i
);

    AST_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_i && tick_i && count_o != '0 && reload_i != '0) |=> (count_o == $past(count_o) - CNT_W'(1))); // R2

    AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_i && !tick_i && reload_i != '0) |=> $stable(count_o)); // R2

    AST_RELOAD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !grant_i |=> (count_o == $past(reload_i))); // R3

    AST_FAULT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_fault_o |=> !bus_fault_o); // R4

    AST_FAULT_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_fault_o |-> (count_o == '0)); // R4

    AST_FAULT_SETS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_fault_o || ext_expire_i) |=> err_o); // R5

    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_o && !(wr_en_i && wr_addr_i == CLR_ADDR)) |=> err_o); // R5

    AST_CLEAR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && wr_addr_i == CLR_ADDR && !bus_fault_o && !ext_expire_i) |=> !err_o); // R7

    AST_OFF_NO_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reload_i == '0 && $past(reload_i) == '0) |-> !bus_fault_o); // R9

endmodule

bind bus_ack_timeout bat_chk #(
    .ADDR_W  (ADDR_W),
    .CNT_W   (CNT_W),
    .CLR_ADDR(CLR_ADDR)
) u_bat_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .grant_i     (grant_i),
    .ext_expire_i(ext_expire_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .count_o     (count_o),
    .bus_fault_o (bus_fault_o),
    .err_o       (err_o),
    .reload_i    (reload_val)
);

// File: tb/tb_bus_ack_timeout.sv
module tb_bus_ack_timeout;

    localparam logic [31:0] A_CLR  = 32'h0004_4000;
    localparam logic [31:0] A_LOAD = 32'h0004_4004;
    localparam logic [31:0] A_OTHER = 32'h0004_4008;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        tick_i = 1'b0;
    logic        grant_i = 1'b0;
    logic        ext_expire_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_addr_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [15:0] count_o;
    logic        bus_fault_o, err_o, irq15_o, diag_led_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk_i = ~clk_i;

    bus_ack_timeout dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (tick_i),
        .grant_i     (grant_i),
        .ext_expire_i(ext_expire_i),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .count_o     (count_o),
        .bus_fault_o (bus_fault_o),
        .err_o       (err_o),
        .irq15_o     (irq15_o),
        .diag_led_o  (diag_led_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk_i);
    endtask

    task automatic write_reg(input logic [31:0] addr, input logic [15:0] data);
        wr_en_i   = 1'b1;
        wr_addr_i = addr;
        wr_data_i = data;
        step(1);
        wr_en_i   = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic t_reset();
        chk("R1", "count", int'(count_o), 100);
        chk("R1", "fault", int'(bus_fault_o), 0);
        chk("R1", "err", int'(err_o), 0);
        chk("R1", "irq", int'(irq15_o), 0);
        chk("R1", "diag", int'(diag_led_o), 0);
    endtask

    task automatic t_expire();
        write_reg(A_LOAD, 16'd5);
        step(1);
        chk("R8", "count after load", int'(count_o), 5);
        grant_i = 1'b1; tick_i = 1'b1;
        step(4);
        chk("R2", "count after 4 ticks", int'(count_o), 1);
        chk("R4", "no early fault", int'(bus_fault_o), 0);
        step(1);
        chk("R4", "count at zero", int'(count_o), 0);
        chk("R4", "fault pulse", int'(bus_fault_o), 1);
        chk("R5", "err not yet", int'(err_o), 0);
        step(1);
        chk("R4", "fault ends", int'(bus_fault_o), 0);
        chk("R5", "err set", int'(err_o), 1);
        chk("R6", "irq", int'(irq15_o), 1);
        chk("R6", "diag", int'(diag_led_o), 1);
        step(3);
        chk("R4", "hold zero", int'(count_o), 0);
        chk("R4", "no repeat pulse", int'(bus_fault_o), 0);
        chk("R5", "err sticky", int'(err_o), 1);
    endtask

    task automatic t_clear();
        write_reg(A_CLR, 16'hFFFF);
        chk("R7", "err cleared", int'(err_o), 0);
        chk("R6", "irq cleared", int'(irq15_o), 0);
        grant_i = 1'b0;
        step(1);
        chk("R3", "reload on idle", int'(count_o), 5);
    endtask

    task automatic t_early_ack();
        grant_i = 1'b1; tick_i = 1'b1;
        step(3);
        chk("R2", "partial count", int'(count_o), 2);
        grant_i = 1'b0;
        step(1);
        chk("R3", "back to reload", int'(count_o), 5);
        step(2);
        chk("R3", "no error", int'(err_o), 0);
        chk("R3", "no fault", int'(bus_fault_o), 0);
    endtask

    task automatic t_no_tick();
        grant_i = 1'b1; tick_i = 1'b0;
        step(5);
        chk("R2", "no tick holds", int'(count_o), 5);
        grant_i = 1'b0;
        step(1);
    endtask

    task automatic t_slow_tick();
        int seen = 0;
        grant_i = 1'b1;
        for (int i = 0; i < 5; i++) begin
            tick_i = 1'b1;
            step(1);
            tick_i = 1'b0;
            if (i == 3) chk("R2", "slow count", int'(count_o), 1);
            if (bus_fault_o) seen++;
            step(3);
            if (bus_fault_o) seen++;
        end
        chk("R4", "slow fault pulses", seen, 1);
        chk("R5", "slow err", int'(err_o), 1);
        grant_i = 1'b0;
        write_reg(A_CLR, 16'd0);
        chk("R7", "slow cleared", int'(err_o), 0);
    endtask

    task automatic t_ext();
        ext_expire_i = 1'b1;
        step(1);
        ext_expire_i = 1'b0;
        chk("R5", "ext sets err", int'(err_o), 1);
        chk("R5", "ext leaves count", int'(count_o), 5);
        chk("R6", "ext irq", int'(irq15_o), 1);
        ext_expire_i = 1'b1;
        write_reg(A_CLR, 16'd0);
        ext_expire_i = 1'b0;
        chk("R7", "set wins over clear", int'(err_o), 1);
    endtask

    task automatic t_other_addr();
        write_reg(A_OTHER, 16'd3);
        step(1);
        chk("R10", "reload unchanged", int'(count_o), 5);
        chk("R10", "err unchanged", int'(err_o), 1);
        write_reg(A_CLR, 16'd0);
        chk("R7", "cleared again", int'(err_o), 0);
    endtask

    task automatic t_disabled();
        int pulses = 0;
        write_reg(A_LOAD, 16'd0);
        step(1);
        chk("R9", "count zero", int'(count_o), 0);
        grant_i = 1'b1; tick_i = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (bus_fault_o) pulses++;
        end
        chk("R9", "no fault when off", pulses, 0);
        chk("R9", "no err when off", int'(err_o), 0);
        chk("R9", "count held", int'(count_o), 0);
        grant_i = 1'b0; tick_i = 1'b0;
    endtask

    initial begin
        step(3);
        rst_ni = 1'b1;
        step(1);
        t_reset();
        t_expire();
        t_clear();
        t_early_ack();
        t_no_tick();
        t_slow_tick();
        t_ext();
        t_other_addr();
        t_disabled();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule